// File: doc/BRIEF.md
# Additive Data-Whitening Scrambler

This block whitens a serial bit stream so that long runs of ones or zeros are broken up and the line spectrum stays balanced. A 15-stage linear feedback generator with polynomial x^15 + x^14 + 1 produces a pseudonoise bit stream. Each valid payload bit is combined with the current pseudonoise bit by exclusive-OR, and the result is registered. The generator is reloaded with a fixed seed at every frame start, so each frame is whitened by the same sequence.

Addition over GF(2) undoes itself. The receive side therefore uses the same block: a scrambled frame fed back through it from the same seed comes out as the original data. The generator advances only when a bit is accepted, so gaps in the input stream do not change the sequence that the payload sees.

Top module: `whiten_scrambler`

## Requirements
- R1: While `rst` is high, the next clock edge clears `out_valid` and `out_bit` to 0 and loads the seed into the generator. After reset, a stream sent without a frame start is scrambled exactly as if a frame start had come first.
- R2: `out_valid` equals `in_valid` one cycle later. When `in_valid` is high, `out_bit` one cycle later equals `in_bit` XOR the current pseudonoise bit.
- R3: The generator stages are numbered 1 to 15. The pseudonoise bit is stage 14 XOR stage 15. On an accepted bit, every stage k takes the old value of stage k-1, and stage 1 takes the pseudonoise bit.
- R4: `frame_start` loads the seed 100101010000000 (stage 1 first, stage 15 last). With all-zero data, the first 14 scrambled bits of a frame are 0,0,0,0,0,0,1,1,1,1,1,1,0,1.
- R5: The generator holds its state on cycles with `in_valid` low. A frame with idle gaps produces the same scrambled bits as the same frame sent without gaps.
- R6: When `frame_start` and `in_valid` are high in the same cycle, that bit is scrambled with the freshly loaded seed state and not with the earlier state.
- R7: `out_bit` keeps its value on cycles after `in_valid` was low.
- R8: A scrambled frame fed back through the block after a new frame start is restored to the original data bit for bit.
- R9: The pseudonoise sequence repeats with a period of 32767 accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Reloads the generator seed; may coincide with a valid bit |
| in_valid | input | 1 | Qualifies `in_bit` and advances the generator |
| in_bit | input | 1 | Payload bit (plain or scrambled) |
| out_valid | output | 1 | `in_valid` delayed by one cycle |
| out_bit | output | 1 | Registered result of the XOR |

## Verification
On every cycle, the assertions check the one-cycle valid delay, the output hold on idle cycles, the freeze of the generator state when no bit is accepted, the shift-and-feedback step, the seed reload, and the first bit after a frame start that coincides with valid data. The bench's scenarios are needed for the parts that take whole frames to show: the exact opening bits from the seed, gap-free and gapped frames giving identical output, the round trip that restores the data, the return to the start after 32767 bits, and the seeding after a reset in the middle of traffic.

// File: rtl/whiten_pkg.sv
package whiten_pkg;

    // Generator depth; state bit i holds stage i+1
    localparam int unsigned PN_STAGES = 15;

    typedef logic [PN_STAGES-1:0] pn_state_t;

    // Seed: stages 1,4,6,8 set (stage 1 is bit 0)
    localparam pn_state_t PN_SEED = 15'b000_0000_1010_1001;

    // Feedback taps at stages 14 and 15
    localparam pn_state_t PN_TAPS = 15'b110_0000_0000_0000;

    // One serial beat of the datapath
    typedef struct packed {
        logic valid;
        logic data;
    } wbit_t;

    // Additive combination over GF(2)
    function automatic logic mix_bit(input logic d, input logic pn);
        return d ^ pn;
    endfunction

endpackage

// File: rtl/whiten_pn_gen.sv
module whiten_pn_gen
    import whiten_pkg::*;
#(
    parameter int unsigned      STAGES = PN_STAGES,
    parameter logic [STAGES-1:0] SEED  = PN_SEED,
    parameter logic [STAGES-1:0] TAPS  = PN_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic              pn_bit,
    output logic [STAGES-1:0] state
);

    logic [STAGES-1:0] cur;
    logic [STAGES-1:0] nxt;

    // A reload in the same cycle as a step uses the seed directly (R6)
    assign cur    = load ? SEED : state;
    assign pn_bit = ^(cur & TAPS);

    // Shift toward the last stage, feedback enters stage 1 (R3)
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign nxt[i] = pn_bit;
        end else begin : g_tail
            assign nxt[i] = cur[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (step) begin
            state <= nxt;
        end else if (load) begin
            state <= SEED;
        end
    end

endmodule

// File: rtl/whiten_mixer.sv
module whiten_mixer
    import whiten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wbit_t in_w,
    input  logic  pn_bit,
    output wbit_t out_w
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_w <= '0;
        end else begin
            out_w.valid <= in_w.valid;
            if (in_w.valid) begin
                out_w.data <= mix_bit(in_w.data, pn_bit);
            end
        end
    end

endmodule

// File: rtl/whiten_scrambler.sv
module whiten_scrambler
    import whiten_pkg::*;
#(
    parameter int unsigned      STAGES = PN_STAGES,
    parameter logic [STAGES-1:0] SEED  = PN_SEED,
    parameter logic [STAGES-1:0] TAPS  = PN_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit
);

    logic              pn_bit;
    logic [STAGES-1:0] gen_state;
    wbit_t             in_w;
    wbit_t             out_w;

    assign in_w.valid = in_valid;
    assign in_w.data  = in_bit;

    whiten_pn_gen #(
        .STAGES (STAGES),
        .SEED   (SEED),
        .TAPS   (TAPS)
    ) u_gen (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_start),
        .step   (in_valid),
        .pn_bit (pn_bit),
        .state  (gen_state)
    );

    whiten_mixer u_mix (
        .clk    (clk),
        .rst    (rst),
        .in_w   (in_w),
        .pn_bit (pn_bit),
        .out_w  (out_w)
    );

    assign out_valid = out_w.valid;
    assign out_bit   = out_w.data;

endmodule

// File: rtl/whiten_scrambler_chk.sv
module whiten_scrambler_chk #(
    parameter int unsigned      STAGES = 15,
    parameter logic [STAGES-1:0] SEED  = '1,
    parameter logic [STAGES-1:0] TAPS  = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              in_valid,
    input logic              in_bit,
    input logic              out_valid,
    input logic              out_bit,
    input logic [STAGES-1:0] gen_state
);

    localparam logic SEED_PN = ^(SEED & TAPS);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_bit && gen_state == SEED));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !frame_start) |=>
            (gen_state[STAGES-1:1] == $past(gen_state[STAGES-2:0])
             && gen_state[0] == $past(^(gen_state & TAPS))));

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !in_valid) |=> gen_state == SEED);

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !frame_start) |=> $stable(gen_state));

    p_first_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_start && in_valid) |=> out_bit == ($past(in_bit) ^ SEED_PN));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_bit));

endmodule

bind whiten_scrambler whiten_scrambler_chk #(
    .STAGES (STAGES),
    .SEED   (SEED),
    .TAPS   (TAPS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_bit      (in_bit),
    .out_valid   (out_valid),
    .out_bit     (out_bit),
    .gen_state   (gen_state)
);

// File: tb/test_whiten_scrambler.sv
`timescale 1ns/1ps
module test_whiten_scrambler;

    localparam int PERIOD = 32767;
    localparam logic [14:0] SEED_BITS = 15'b000_0000_1010_1001; // bit i = stage i+1 (R4)
    localparam logic [13:0] OPENING   = 14'b10_1111_1100_0000;  // bit k = k-th bit (R4)
    localparam int FLEN = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid;
    logic out_bit;

    int checks = 0;
    int errors = 0;

    logic mq[$];
    logic cap[$];
    logic exp_v = 1'b0;
    logic exp_b = 1'b0;
    logic ref_frame[FLEN];
    logic scr_frame[FLEN];

    always #2 clk = ~clk;

    whiten_scrambler i_whiten_scrambler (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .out_valid   (out_valid),
        .out_bit     (out_bit)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_seed();
        mq.delete();
        for (int i = 0; i < 15; i++) mq.push_back(SEED_BITS[i]);
    endtask

    function automatic logic data_pat(input int i);
        return ((i * 5 + 3) % 7) < 3;
    endfunction

    // Called at a negative edge: drive, take one edge, update model, compare
    task automatic step(input logic st, input logic v, input logic b);
        logic pn;
        frame_start = st;
        in_valid    = v;
        in_bit      = b;
        @(posedge clk);
        if (rst) begin
            model_seed();
            exp_v = 1'b0;
            exp_b = 1'b0;
        end else begin
            if (st) model_seed();
            if (v) begin
                pn = mq[13] ^ mq[14];
                exp_b = b ^ pn;
                mq.push_front(pn);
                void'(mq.pop_back());
            end
            exp_v = v;
        end
        @(negedge clk);
        check("R2 out_valid", out_valid, exp_v);
        check("R2 out_bit", out_bit, exp_b);
        if (out_valid) cap.push_back(out_bit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic held;
        model_seed();
        @(negedge clk);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        check("R1 reset out_valid", out_valid, 1'b0);
        check("R1 reset out_bit", out_bit, 1'b0);
        rst = 1'b0;

        // Opening bits from the seed with zero data (R4, R3)
        cap.delete();
        step(1'b1, 1'b1, 1'b0);
        for (int i = 1; i < 14; i++) step(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 14; i++) check("R4 opening bit", cap[i], OPENING[i]);

        // Frame start with valid on mid-stream state (R6)
        cap.delete();
        step(1'b1, 1'b1, data_pat(0));
        check("R6 first bit uses seed", cap[0], data_pat(0) ^ 1'b0);
        for (int i = 1; i < FLEN; i++) step(1'b0, 1'b1, data_pat(i));
        for (int i = 0; i < FLEN; i++) scr_frame[i] = cap[i];

        // Same frame with idle gaps; frame start alone first (R5, R7)
        cap.delete();
        step(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < FLEN; i++) begin
            step(1'b0, 1'b1, data_pat(i));
            if (i % 3 == 0) begin
                held = out_bit;
                step(1'b0, 1'b0, ~data_pat(i));
                check("R7 out_bit held on idle", out_bit, held);
            end
        end
        for (int i = 0; i < FLEN; i++) check("R5 gapped frame equal", cap[i], scr_frame[i]);

        // Round trip restores data (R8)
        cap.delete();
        step(1'b1, 1'b1, scr_frame[0]);
        for (int i = 1; i < FLEN; i++) step(1'b0, 1'b1, scr_frame[i]);
        for (int i = 0; i < FLEN; i++) begin
            ref_frame[i] = data_pat(i);
            check("R8 descrambled bit", cap[i], ref_frame[i]);
        end

        // Reset in the middle of traffic reseeds the generator (R1)
        step(1'b0, 1'b1, 1'b1);
        rst = 1'b1;
        step(1'b0, 1'b1, 1'b1);
        check("R1 mid reset out_valid", out_valid, 1'b0);
        rst = 1'b0;
        cap.delete();
        for (int i = 0; i < 14; i++) step(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 14; i++) check("R1 seeded after reset", cap[i], OPENING[i]);

        // Period of the sequence (R9)
        cap.delete();
        step(1'b1, 1'b1, 1'b0);
        for (int i = 1; i < PERIOD + 15; i++) step(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 15; i++) check("R9 period repeat", cap[PERIOD + i], cap[i]);

        step(1'b0, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule